// File: doc/BRIEF.md
# Character LCD Bus Timing Adapter

This block connects a processor's asynchronous-style local bus (active-low select, read strobe and write strobe, two low address bits, a data byte) to a character display controller that expects a register-select line, a direction line and an enable strobe. On a host bus, the select and the address can move at the same moment. A decoded select therefore cannot serve as the enable. The adapter instead recognises a qualified access, captures the two address bits and the write data into registers, and then generates the display enable from a one-hot shift chain clocked by the system clock.

The chain runs for `SETUP_CYC + EN_CYC + HOLD_CYC` clocks. For the first `SETUP_CYC` clocks only the register-select and direction lines are driven. Enable is then high for `EN_CYC` clocks. For the final `HOLD_CYC` clocks the lines stay frozen after enable has dropped. A wait output holds the host for the whole sequence. For display reads, the display data is captured on the edge that ends the enable pulse. It is returned to the host until the host releases its strobe.

`SETUP_CYC` must be chosen so that `SETUP_CYC` times the clock period is at least the display's 50 ns address setup time. The bus inputs are assumed synchronous to `clk`.

Top module: `lcd_bus_adapter`

## Requirements
- R1: An access is qualified only when `bus_cs_n` is low and at least one of `bus_rd_n`, `bus_wr_n` is low. Select alone, or a strobe without select, never raises `bus_wait` or `disp_en`.
- R2: On the clock edge that accepts a qualified access, `disp_rs` takes `bus_addr[0]` and `disp_rw` takes `bus_addr[1]`. Both then hold that value for the whole sequence, whatever the address does afterwards.
- R3: `bus_wait` rises on the accepting edge and stays high for exactly `SETUP_CYC+EN_CYC+HOLD_CYC` clocks.
- R4: `disp_en` rises exactly `SETUP_CYC` clocks after `bus_wait` rises.
- R5: `disp_en` stays high for exactly `EN_CYC` clocks, and only while `bus_wait` is high.
- R6: After `disp_en` falls, `bus_wait` stays high for `HOLD_CYC` more clocks. During that time `disp_rs`, `disp_rw` and `disp_dout` do not change.
- R7: When `disp_rw` is 0 (display write), `disp_dout` carries `bus_wdata` as captured on the accepting edge, and `disp_doe` is high for the whole sequence. When `disp_rw` is 1, and when idle, `disp_doe` is low.
- R8: When `disp_rw` is 1, `disp_din` is sampled on the edge where `disp_en` falls. From that edge on, `bus_rdata` shows the sampled value and `bus_rvalid` is high until the strobe or select is released.
- R9: One continuous strobe produces exactly one enable pulse. A new access is accepted only after the qualified condition has been seen low. If the strobe is released and reasserted during a sequence, the new access starts on the first clock after `bus_wait` has been low for one clock.
- R10: In reset, `disp_en`, `bus_wait`, `disp_doe` and `bus_rvalid` are low. An access that is already active when reset ends is ignored until it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Host peripheral select, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_addr | input | 2 | Low host address bits: [0] to register select, [1] to direction |
| bus_wdata | input | DW | Host write data |
| disp_din | input | DW | Data returned by the display |
| disp_rs | output | 1 | Display register select |
| disp_rw | output | 1 | Display direction, 1 = read |
| disp_en | output | 1 | Display enable strobe |
| disp_dout | output | DW | Data driven to the display |
| disp_doe | output | 1 | Output enable for `disp_dout` |
| bus_wait | output | 1 | Holds the host bus cycle while high |
| bus_rdata | output | DW | Data sampled from the display |
| bus_rvalid | output | 1 | `bus_rdata` is valid for the current host read |

## Verification
The embedded assertions check every cycle that the captured select and direction match the address seen on the accepting edge. They also check that these lines and the write data stay frozen while the sequence runs, that enable rises and falls at the exact clock counts after wait rises, that wait lasts the full sequence, and that enable and data drive occur only inside wait. Some behaviours can only be shown by the bench scenarios: that select-only and strobe-only patterns are rejected, that a held strobe fires once, that a mid-sequence release and reassert restarts after the one-clock gap, and that an access held across reset is ignored. The same applies to the read-sample point, which the bench pins down by changing the display data right after the falling enable edge.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

  typedef struct packed {
    logic rs;
    logic rw;
  } lcdb_sel_t;

  function automatic int unsigned lcdb_seq_len(input int unsigned s, input int unsigned e,
                                               input int unsigned h);
    return s + e + h;
  endfunction

endpackage

// File: rtl/lcdb_qualify.sv
module lcdb_qualify (
  input  logic clk,
  input  logic rst,
  input  logic bus_cs_n,
  input  logic bus_rd_n,
  input  logic bus_wr_n,
  input  logic busy,
  output logic qual,
  output logic start
);

  logic armed_q;

  always_comb begin
    qual  = ~bus_cs_n & (~bus_rd_n | ~bus_wr_n);
    start = qual & armed_q & ~busy;
  end

  // Re-arm only after the qualified condition has been seen low.
  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b0;
    else if (start)  armed_q <= 1'b0;
    else if (!qual)  armed_q <= 1'b1;
  end

  assert_single_start_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

endmodule

// File: rtl/lcdb_chain.sv
module lcdb_chain #(
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned EN_CYC    = 12,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic en,
  output logic sample,
  output logic last
);

  localparam int unsigned L  = lcdb_pkg::lcdb_seq_len(SETUP_CYC, EN_CYC, HOLD_CYC);
  localparam int unsigned CW = $clog2(L + 1);
  localparam logic [L-1:0] EN_MASK = {{HOLD_CYC{1'b0}}, {EN_CYC{1'b1}}, {SETUP_CYC{1'b0}}};

  logic [L-1:0] chain_q, chain_nxt;
  logic         busy_q, en_q;

  always_comb begin
    if (start) chain_nxt = {{(L-1){1'b0}}, 1'b1};
    else       chain_nxt = chain_q << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      busy_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      chain_q <= chain_nxt;
      busy_q  <= |chain_nxt;
      en_q    <= |(chain_nxt & EN_MASK);
    end
  end

  assign busy   = busy_q;
  assign en     = en_q;
  assign sample = chain_q[SETUP_CYC+EN_CYC-1];
  assign last   = chain_q[L-1];

  // Cycle counter since wait rose, used only by the checks below.
  logic [CW-1:0] cyc_q;
  always_ff @(posedge clk) begin
    if (rst || !busy_q) cyc_q <= '0;
    else                cyc_q <= cyc_q + 1'b1;
  end

  assert_en_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> (busy_q && int'(cyc_q) == SETUP_CYC));

  assert_en_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> (busy_q && int'(cyc_q) == SETUP_CYC + EN_CYC));

  assert_wait_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> int'($past(cyc_q)) == L - 1);

endmodule

// File: rtl/lcdb_latch.sv
module lcdb_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          busy,
  input  logic          sample,
  input  logic          last,
  input  logic          qual,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] disp_din,
  output logic          disp_rs,
  output logic          disp_rw,
  output logic [DW-1:0] disp_dout,
  output logic          disp_doe,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid
);

  lcdb_pkg::lcdb_sel_t sel_q;
  logic [DW-1:0] wd_q, rd_q;
  logic          doe_q, rv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      wd_q  <= '0;
      doe_q <= 1'b0;
    end else if (start) begin
      sel_q.rs <= bus_addr[0];
      sel_q.rw <= bus_addr[1];
      wd_q     <= bus_wdata;
      doe_q    <= ~bus_addr[1];
    end else if (last) begin
      doe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      if (sample && sel_q.rw) rd_q <= disp_din;
      if (!qual)                   rv_q <= 1'b0;
      else if (sample && sel_q.rw) rv_q <= 1'b1;
    end
  end

  assign disp_rs    = sel_q.rs;
  assign disp_rw    = sel_q.rw;
  assign disp_dout  = wd_q;
  assign disp_doe   = doe_q;
  assign bus_rdata  = rd_q;
  assign bus_rvalid = rv_q;

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (disp_rs == $past(bus_addr[0]) && disp_rw == $past(bus_addr[1])));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(disp_rs) && $stable(disp_rw) && $stable(disp_dout)));

endmodule

// File: rtl/lcd_bus_adapter.sv
module lcd_bus_adapter #(
  parameter int unsigned DW        = 8,
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned EN_CYC    = 12,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] disp_din,
  output logic          disp_rs,
  output logic          disp_rw,
  output logic          disp_en,
  output logic [DW-1:0] disp_dout,
  output logic          disp_doe,
  output logic          bus_wait,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid
);

  logic qual, start, busy, sample, last;

  lcdb_qualify u_qual (
    .clk      (clk),
    .rst      (rst),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .busy     (busy),
    .qual     (qual),
    .start    (start)
  );

  lcdb_chain #(
    .SETUP_CYC (SETUP_CYC),
    .EN_CYC    (EN_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_chain (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .en     (disp_en),
    .sample (sample),
    .last   (last)
  );

  lcdb_latch #(.DW(DW)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .sample     (sample),
    .last       (last),
    .qual       (qual),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .disp_din   (disp_din),
    .disp_rs    (disp_rs),
    .disp_rw    (disp_rw),
    .disp_dout  (disp_dout),
    .disp_doe   (disp_doe),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  assign bus_wait = busy;

  assert_en_in_wait_R5: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> bus_wait);

  assert_doe_in_wait_R7: assert property (@(posedge clk) disable iff (rst)
    disp_doe |-> (bus_wait && !disp_rw));

endmodule

// File: tb/tb_lcd_bus_adapter.sv
module tb_lcd_bus_adapter;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int S  = 3;
  localparam int E  = 4;
  localparam int H  = 2;
  localparam int L  = S + E + H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0, din = '0;
  logic rs, rw, en, doe, wt, rvalid;
  logic [DW-1:0] dout, rdata;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_bus_adapter #(.DW(DW), .SETUP_CYC(S), .EN_CYC(E), .HOLD_CYC(H)) dut (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
    .bus_addr(addr), .bus_wdata(wdata), .disp_din(din),
    .disp_rs(rs), .disp_rw(rw), .disp_en(en), .disp_dout(dout), .disp_doe(doe),
    .bus_wait(wt), .bus_rdata(rdata), .bus_rvalid(rvalid)
  );

  task automatic chk(input bit ok, input string req, input int k,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at k=%0d actual=%0h expected=%0h", req, k, act, exp);
    end
  endtask

  // Grouped check: counted once per access, reports the first mismatch.
  task automatic grp(input bit ok, input string req, input int k,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     inout bit bad);
    if (!ok && !bad) begin
      bad = 1'b1;
      $display("FAIL %s at k=%0d actual=%0h expected=%0h", req, k, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] a, input bit use_rd,
                        input logic [DW-1:0] wd, input logic [DW-1:0] rdin);
    bit b_w = 0, b_e = 0, b_sel = 0, b_d = 0, b_r = 0;
    @(negedge clk);
    addr = a; wdata = wd; din = rdin; cs_n = 1'b0;
    if (use_rd) rd_n = 1'b0; else wr_n = 1'b0;
    for (int k = 1; k <= L + 6; k++) begin
      @(negedge clk);
      // R3 / R6: wait covers k=1..L
      grp(wt === (k <= L), "R3/R6 wait", k, wt, (k <= L), b_w);
      // R4 / R5 / R9: enable only for k=S+1..S+E, none after
      grp(en === (k >= S+1 && k <= S+E), "R4/R5/R9 enable", k, en, (k >= S+1 && k <= S+E), b_e);
      if (k <= L) begin
        // R2 / R6: select lines frozen despite the address change at k=1
        grp(rs === a[0] && rw === a[1], "R2/R6 rs/rw", k, {rs, rw}, {a[0], a[1]}, b_sel);
        // R7: drive enable and data
        grp(doe === ~a[1], "R7 doe", k, doe, ~a[1], b_d);
        if (!a[1]) grp(dout === wd, "R7 dout", k, dout, wd, b_d);
      end else begin
        grp(doe === 1'b0, "R7 doe idle", k, doe, 0, b_d);
      end
      // R8: read data from the falling enable edge on
      grp(rvalid === (a[1] && k >= S+E+1), "R8 rvalid", k, rvalid, (a[1] && k >= S+E+1), b_r);
      if (a[1] && k >= S+E+1) grp(rdata === rdin, "R8 rdata", k, rdata, rdin, b_r);
      if (k == 1) begin addr = ~a; wdata = ~wd; end
      if (k == S+E+1) din = ~rdin;
    end
    n_chk += 5;
    n_err += b_w + b_e + b_sel + b_d + b_r;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk(rvalid === 1'b0 && wt === 1'b0, "R8 rvalid clear on release", 0, {rvalid, wt}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin : main
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(en === 0 && wt === 0 && doe === 0 && rvalid === 0, "R10 reset state", 0,
        {en, wt, doe, rvalid}, 0);

    // R1: select alone, then strobe alone
    cs_n = 1'b0; seen = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (wt || en) seen = 1; end
    chk(!seen, "R1 select alone", 0, seen, 0);
    cs_n = 1'b1; rd_n = 1'b0; wr_n = 1'b0; seen = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (wt || en) seen = 1; end
    chk(!seen, "R1 strobe alone", 0, seen, 0);
    rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);

    // Sweep of all address values with both strobe kinds (R2..R8)
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 2; s++)
        access(a[1:0], s[0], 8'h30 + 8'(a*2+s), 8'hA0 + 8'(a*2+s));

    // R9: release and reassert during a sequence
    @(negedge clk);
    addr = 2'b00; wdata = 8'h5A; cs_n = 1'b0; wr_n = 1'b0;
    for (int k = 1; k <= 2*L + 3; k++) begin
      @(negedge clk);
      if (k == L+1) chk(wt === 1'b0, "R9 gap before restart", k, wt, 0);
      if (k == L+2) chk(wt === 1'b1, "R9 restart after gap", k, wt, 1);
      if (k == L+S+2) chk(en === 1'b1, "R9 second enable", k, en, 1);
      if (k == 2) wr_n = 1'b1;
      if (k == 3) wr_n = 1'b0;
    end
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: access held across reset is ignored until released
    cs_n = 1'b0; wr_n = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; seen = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (wt || en) seen = 1; end
    chk(!seen, "R10 held access ignored", 0, seen, 0);
    wr_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b0;
    @(negedge clk);
    chk(wt === 1'b1, "R10 accepted after release", 0, wt, 1);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (L + 2) @(negedge clk);
    chk(wt === 1'b0 && en === 1'b0, "R3 idle at end", 0, {wt, en}, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule